// File: doc/BRIEF.md
# Tagged Translation Lookaside Cache with Recency Replacement

This block caches recent virtual-to-physical page translations for one address source. Each lookup presents a virtual page number, a process tag and an access kind. Every stored entry is compared against the request in parallel. In the same cycle the block reports exactly one of three results: a hit with the physical page number, a protection fault, or a miss. A hit or fault is reported only when a valid entry's page number and tag both match the request. A miss tells the external page-table walker to fetch the mapping and hand it back through the refill port.

Entries are kept in recency order. A successful hit promotes its entry to most-recent on the next clock edge. A refill uses a free slot when one exists, overwrites an entry that already holds the same page and tag, and otherwise evicts the least recently used entry. Two maintenance inputs keep the cache coherent with the page tables. One drops a single mapping selected by page number and tag; the other empties the whole cache, for example on a context switch when tags are not in use. A parameter selects whether the process tag takes part in matching.

Top module: `tlb_lru_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: A lookup that matches a valid entry on page number and tag, with the access permitted, raises `lk_hit` in the same cycle and drives that entry's physical page number on `lk_ppn`.
- R3: An entry whose page number matches but whose process tag differs does not match, and the lookup misses.
- R4: The access code is 0 for read, 1 for write, 2 for execute, and 3 is never permitted. Permission bit 0 grants read, bit 1 grants write and bit 2 grants execute. A matching entry that lacks the requested right raises `lk_fault` with `lk_ppn` at zero and no hit.
- R5: While `lk_valid` is high exactly one of `lk_hit`, `lk_fault` and `lk_miss` is high. While it is low all three are low.
- R6: A refill made while a free entry exists takes that free entry and evicts no valid mapping.
- R7: When the cache is full, a refill evicts the least recently used entry. A hit makes its entry most recent at the next clock edge, and faults and misses leave the order unchanged.
- R8: A refill whose page number and tag match a stored entry overwrites that entry's frame and permissions and does not occupy a second entry.
- R9: An invalidate request removes only the entry that matches both its page number and its tag. From the next cycle that mapping misses and all other entries still hit.
- R10: A flush invalidates every entry at the next clock edge and takes priority over a refill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_tag | input | 8 | Lookup process tag |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Entry found but access right missing |
| lk_miss | output | 1 | No matching valid entry |
| lk_ppn | output | 20 | Translated physical page number, zero unless hit |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_tag | input | 8 | Refill process tag |
| fill_ppn | input | 20 | Refill physical page number |
| fill_perm | input | 3 | Refill permissions {execute, write, read} |
| inv_valid | input | 1 | Invalidate one mapping |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_tag | input | 8 | Process tag to invalidate |
| flush | input | 1 | Invalidate every entry |

## Verification
On every cycle the assertions check the following: the three lookup results are mutually exclusive and complete, at most one entry ever matches a key, exactly one entry holds the least-recent position, a fault never carries a frame number, and a flush leaves no hit behind. They also check that a mapping refilled in one cycle does not miss in the next, and that an invalidated mapping misses in the next. Only the bench scenarios can show which entry the replacement choice actually evicts. That covers LRU eviction after a series of hits, the preference for a free slot, the overwrite of a duplicate refill, and the flush that wins over a refill in the same cycle. The bench checks these by probing which mappings are still resident.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int PERM_W   = 3;
   localparam int PERM_RD  = 0;
   localparam int PERM_WR  = 1;
   localparam int PERM_EX  = 2;

   // R4: access kind against the entry's right bits
   function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                        input logic [1:0] acc);
      logic ok;
      case (acc_e'(acc))
         ACC_READ:  ok = perm[PERM_RD];
         ACC_WRITE: ok = perm[PERM_WR];
         ACC_EXEC:  ok = perm[PERM_EX];
         default:   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int N        = 8,
   parameter int VPN_W    = 20,
   parameter int TAG_W    = 8,
   parameter bit USE_TAGS = 1'b1
) (
   input  logic [N-1:0]            ent_valid,
   input  logic [N-1:0][VPN_W-1:0] ent_vpn,
   input  logic [N-1:0][TAG_W-1:0] ent_tag,
   input  logic [VPN_W-1:0]        key_vpn,
   input  logic [TAG_W-1:0]        key_tag,
   output logic [N-1:0]            match
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      logic vpn_eq;
      logic tag_eq;
      assign vpn_eq = (ent_vpn[i] == key_vpn);
      if (USE_TAGS) begin : g_tagged
         assign tag_eq = (ent_tag[i] == key_tag);
      end else begin : g_untagged
         logic unused_tag;
         assign unused_tag = ^{ent_tag[i], key_tag};
         assign tag_eq = 1'b1;
      end
      assign match[i] = ent_valid[i] & vpn_eq & tag_eq;
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N     = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     ent_valid,
   input  logic [N-1:0]     lru_vec,
   output logic [IDX_W-1:0] victim
);
   logic [IDX_W-1:0] free_idx;
   logic             free_found;
   logic [IDX_W-1:0] lru_idx;

   always_comb begin
      free_idx   = '0;
      free_found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!ent_valid[i]) begin
            free_idx   = IDX_W'(i);
            free_found = 1'b1;
         end
      end
   end

   always_comb begin
      lru_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (lru_vec[i]) lru_idx = IDX_W'(i);
      end
   end

   assign victim = free_found ? free_idx : lru_idx;
endmodule

// File: rtl/tlb_recency.sv
module tlb_recency #(
   parameter int N     = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      touch_en,
   input  logic [IDX_W-1:0]          touch_idx,
   output logic [N-1:0]              lru_vec,
   output logic [N-1:0][IDX_W-1:0]   rank
);
   // rank 0 is most recent, N-1 is least recent
   logic [IDX_W-1:0] touched_rank;

   always_comb begin
      touched_rank = '0;
      for (int i = 0; i < N; i++) begin
         if (touch_idx == IDX_W'(i)) touched_rank = rank[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) rank[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (touch_idx == IDX_W'(i))
               rank[i] <= '0;
            else if (rank[i] < touched_rank)
               rank[i] <= rank[i] + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_lru
      assign lru_vec[i] = (rank[i] == IDX_W'(N - 1));
   end
endmodule

// File: rtl/tlb_lru_cache.sv
module tlb_lru_cache
   import tlb_pkg::*;
#(
   parameter int ENTRIES  = 8,
   parameter int VPN_W    = 20,
   parameter int PPN_W    = 20,
   parameter int TAG_W    = 8,
   parameter bit USE_TAGS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [TAG_W-1:0]   lk_tag,
   input  logic [1:0]         lk_acc,
   output logic               lk_hit,
   output logic               lk_fault,
   output logic               lk_miss,
   output logic [PPN_W-1:0]   lk_ppn,
   input  logic               fill_valid,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [TAG_W-1:0]   fill_tag,
   input  logic [PPN_W-1:0]   fill_ppn,
   input  logic [PERM_W-1:0]  fill_perm,
   input  logic               inv_valid,
   input  logic [VPN_W-1:0]   inv_vpn,
   input  logic [TAG_W-1:0]   inv_tag,
   input  logic               flush
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   // entry storage
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
   logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
   logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
   logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] fill_match;
   logic [ENTRIES-1:0] inv_match;
   logic [ENTRIES-1:0] lru_vec;
   logic [ENTRIES-1:0][IDX_W-1:0] rank;

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W), .USE_TAGS(USE_TAGS)) u_lk_cmp (
      .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_tag(tag_q),
      .key_vpn(lk_vpn), .key_tag(lk_tag), .match(lk_match));

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W), .USE_TAGS(USE_TAGS)) u_fill_cmp (
      .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_tag(tag_q),
      .key_vpn(fill_vpn), .key_tag(fill_tag), .match(fill_match));

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W), .USE_TAGS(USE_TAGS)) u_inv_cmp (
      .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_tag(tag_q),
      .key_vpn(inv_vpn), .key_tag(inv_tag), .match(inv_match));

   // lookup read-out: one-hot mux over the matching entry
   logic [IDX_W-1:0]  lk_idx;
   logic [PPN_W-1:0]  sel_ppn;
   logic [PERM_W-1:0] sel_perm;
   logic              any_match;
   logic              allowed;

   always_comb begin
      lk_idx   = '0;
      sel_ppn  = '0;
      sel_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) begin
            lk_idx   = IDX_W'(i);
            sel_ppn  = sel_ppn | ppn_q[i];
            sel_perm = sel_perm | perm_q[i];
         end
      end
   end

   assign any_match = |lk_match;
   assign allowed   = perm_allows(sel_perm, lk_acc);
   assign lk_hit    = lk_valid & any_match & allowed;
   assign lk_fault  = lk_valid & any_match & ~allowed;
   assign lk_miss   = lk_valid & ~any_match;
   assign lk_ppn    = lk_hit ? sel_ppn : '0;

   // refill slot: existing duplicate first, else free slot, else LRU
   logic [IDX_W-1:0] victim_idx;
   logic [IDX_W-1:0] dup_idx;
   logic [IDX_W-1:0] fill_idx;

   tlb_victim #(.N(ENTRIES)) u_victim (
      .ent_valid(valid_q), .lru_vec(lru_vec), .victim(victim_idx));

   always_comb begin
      dup_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (fill_match[i]) dup_idx = IDX_W'(i);
      end
   end

   assign fill_idx = (|fill_match) ? dup_idx : victim_idx;

   // recency: refill wins over a hit in the same cycle, flush touches nothing
   logic             touch_en;
   logic [IDX_W-1:0] touch_idx;
   logic             do_fill;

   assign do_fill   = fill_valid & ~flush;
   assign touch_en  = ~flush & (fill_valid | lk_hit);
   assign touch_idx = fill_valid ? fill_idx : lk_idx;

   tlb_recency #(.N(ENTRIES)) u_recency (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
      .lru_vec(lru_vec), .rank(rank));

   logic [ENTRIES-1:0] valid_nxt;

   always_comb begin
      if (flush) begin
         valid_nxt = '0;
      end else begin
         valid_nxt = valid_q & ~(inv_valid ? inv_match : '0);
         if (do_fill) valid_nxt[fill_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         valid_q <= valid_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         vpn_q[fill_idx]  <= fill_vpn;
         tag_q[fill_idx]  <= fill_tag;
         ppn_q[fill_idx]  <= fill_ppn;
         perm_q[fill_idx] <= fill_perm;
      end
   end
endmodule

// File: rtl/tlb_lru_cache_chk.sv
module tlb_lru_cache_chk #(
   parameter int N     = 8,
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int TAG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [VPN_W-1:0] lk_vpn,
   input logic [TAG_W-1:0] lk_tag,
   input logic             lk_hit,
   input logic             lk_fault,
   input logic             lk_miss,
   input logic [PPN_W-1:0] lk_ppn,
   input logic             fill_valid,
   input logic [VPN_W-1:0] fill_vpn,
   input logic [TAG_W-1:0] fill_tag,
   input logic             inv_valid,
   input logic [VPN_W-1:0] inv_vpn,
   input logic [TAG_W-1:0] inv_tag,
   input logic             flush,
   input logic [N-1:0]     lk_match,
   input logic [N-1:0]     lru_vec
);
   a_r5_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $onehot({lk_hit, lk_fault, lk_miss}));

   a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_fault || lk_miss));

   a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   a_r7_one_lru: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(lru_vec));

   a_r4_fault_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> (lk_ppn == '0));

   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !(lk_hit || lk_fault));

   a_r2_fill_resident: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush) ##1
      (lk_valid && lk_vpn == $past(fill_vpn) && lk_tag == $past(fill_tag)) |-> !lk_miss);

   a_r9_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !fill_valid) ##1
      (lk_valid && lk_vpn == $past(inv_vpn) && lk_tag == $past(inv_tag)) |-> lk_miss);
endmodule

bind tlb_lru_cache tlb_lru_cache_chk #(
   .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .TAG_W(TAG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_tag(lk_tag),
   .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_miss(lk_miss), .lk_ppn(lk_ppn),
   .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_tag(fill_tag),
   .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_tag(inv_tag), .flush(flush),
   .lk_match(lk_match), .lru_vec(lru_vec));

// File: tb/tlb_lru_cache_bench.sv
module tlb_lru_cache_bench;
   localparam int K_MISS  = 0;
   localparam int K_HIT   = 1;
   localparam int K_FAULT = 2;
   localparam int NVEC    = 7;

   // {vpn, tag, acc, expected kind, expected ppn}
   localparam logic [51:0] VEC [NVEC] = '{
      {20'h00100, 8'd1, 2'd0, 2'd1, 20'h00500},   // R2 read hit
      {20'h00103, 8'd1, 2'd1, 2'd2, 20'h00000},   // R4 write on read-only
      {20'h00103, 8'd1, 2'd0, 2'd1, 20'h00503},   // R2 read-only read
      {20'h00105, 8'd2, 2'd0, 2'd0, 20'h00000},   // R3 other tag
      {20'h00107, 8'd1, 2'd2, 2'd1, 20'h00507},   // R2 exec hit
      {20'h001FF, 8'd1, 2'd0, 2'd0, 20'h00000},   // R5 unmapped page
      {20'h00103, 8'd1, 2'd2, 2'd2, 20'h00000}    // R4 exec on read-only
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [7:0]  lk_tag = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_hit, lk_fault, lk_miss;
   logic [19:0] lk_ppn;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [7:0]  fill_tag = '0;
   logic [19:0] fill_ppn = '0;
   logic [2:0]  fill_perm = '0;
   logic        inv_valid = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic [7:0]  inv_tag = '0;
   logic        flush = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   tlb_lru_cache u_tlb_lru_cache (.*);

   task automatic lookup(input logic [19:0] vpn, input logic [7:0] tag, input logic [1:0] acc,
                         input int exp_kind, input logic [19:0] exp_ppn, input string req);
      int act;
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = vpn; lk_tag = tag; lk_acc = acc;
      #2;
      if ($countones({lk_hit, lk_fault, lk_miss}) != 1) act = 3;
      else if (lk_hit) act = K_HIT;
      else if (lk_fault) act = K_FAULT;
      else act = K_MISS;
      n_checks++;
      if (act != exp_kind || lk_ppn != exp_ppn) begin
         n_fails++;
         $display("FAIL %s vpn=%h: kind=%0d ppn=%h, expected kind=%0d ppn=%h",
                  req, vpn, act, lk_ppn, exp_kind, exp_ppn);
      end
      @(posedge clk); #1;
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [7:0] tag,
                       input logic [19:0] ppn, input logic [2:0] perm);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn; fill_tag = tag; fill_ppn = ppn; fill_perm = perm;
      @(posedge clk); #1;
      fill_valid = 1'b0;
   endtask

   task automatic invalidate(input logic [19:0] vpn, input logic [7:0] tag);
      @(negedge clk);
      inv_valid = 1'b1; inv_vpn = vpn; inv_tag = tag;
      @(posedge clk); #1;
      inv_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: empty after reset; R5 idle outputs quiet
      @(negedge clk);
      n_checks++;
      if (lk_hit || lk_fault || lk_miss) begin
         n_fails++;
         $display("FAIL R5 idle flags=%b expected 000", {lk_hit, lk_fault, lk_miss});
      end
      lookup(20'h00100, 8'd1, 2'd0, K_MISS, 20'h0, "R1");

      // R6: eight fills into free slots, entry 3 read-only
      for (int i = 0; i < 8; i++)
         fill(20'h00100 + 20'(i), 8'd1, 20'h00500 + 20'(i), (i == 3) ? 3'b001 : 3'b111);

      for (int v = 0; v < NVEC; v++)
         lookup(VEC[v][51:32], VEC[v][31:24], VEC[v][23:22], int'(VEC[v][21:20]),
                VEC[v][19:0], "R2/R3/R4/R6 vector");

      // recency now MRU->LRU: 107,103,100,106,105,104,102,101
      fill(20'h00200, 8'd1, 20'h00600, 3'b111);
      lookup(20'h00101, 8'd1, 2'd0, K_MISS, 20'h0, "R7 LRU evicted");
      lookup(20'h00200, 8'd1, 2'd0, K_HIT, 20'h00600, "R7 refilled");
      lookup(20'h00102, 8'd1, 2'd0, K_HIT, 20'h00502, "R7 hit promotes");
      fill(20'h00201, 8'd1, 20'h00601, 3'b111);
      lookup(20'h00104, 8'd1, 2'd0, K_MISS, 20'h0, "R7 next LRU evicted");
      lookup(20'h00102, 8'd1, 2'd0, K_HIT, 20'h00502, "R7 promoted survives");

      // R8: overwrite of an existing mapping
      fill(20'h00200, 8'd1, 20'h00777, 3'b001);
      lookup(20'h00200, 8'd1, 2'd0, K_HIT, 20'h00777, "R8 new frame");
      lookup(20'h00200, 8'd1, 2'd1, K_FAULT, 20'h0, "R8 new rights");
      lookup(20'h00105, 8'd1, 2'd0, K_HIT, 20'h00505, "R8 no second slot");

      // R9: single invalidate, wrong tag has no effect
      invalidate(20'h00107, 8'd1);
      lookup(20'h00107, 8'd1, 2'd0, K_MISS, 20'h0, "R9 removed");
      invalidate(20'h00100, 8'd2);
      lookup(20'h00100, 8'd1, 2'd0, K_HIT, 20'h00500, "R9 other tag kept");

      // R6: refill takes the freed slot, LRU (106) survives
      fill(20'h00300, 8'd1, 20'h00800, 3'b111);
      lookup(20'h00106, 8'd1, 2'd0, K_HIT, 20'h00506, "R6 LRU kept");
      lookup(20'h00300, 8'd1, 2'd0, K_HIT, 20'h00800, "R6 refill");

      // R10: flush, and flush beats a same-cycle refill
      @(negedge clk);
      flush = 1'b1;
      fill_valid = 1'b1; fill_vpn = 20'h00400; fill_tag = 8'd1;
      fill_ppn = 20'h00900; fill_perm = 3'b111;
      @(posedge clk); #1;
      flush = 1'b0; fill_valid = 1'b0;
      lookup(20'h00300, 8'd1, 2'd0, K_MISS, 20'h0, "R10 flushed");
      lookup(20'h00400, 8'd1, 2'd0, K_MISS, 20'h0, "R10 flush over refill");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule